// File: doc/BRIEF.md
# Event-Driven PWM Channel

This block produces one pulse-width-modulated output. A prescaler turns the core clock into counting ticks. A 16-bit counter advances on each tick in one of three patterns: ramping up, ramping down, or a triangle that goes up and then down. The counter reports three kinds of events: it arrives at zero, it arrives at the period value, or it arrives at the compare value. A compare arrival is further split by the direction of the step that produced it.

Each event kind has its own programmable reaction: force the output low, force it high, or leave it as it is. The output is therefore an arbitrary set/clear pattern rather than a fixed edge-aligned waveform. A typical setup is "high at zero, low at compare". The compare value then sets the duty cycle and the period value sets the frequency.

The period and compare inputs are captured into shadow copies only at the start of each counting cycle, so software may change them at any time without tearing a cycle. The output pin is gated by an enable, and each event also appears as a one-cycle strobe.

Top module: `pwm_channel`

## Requirements
- R1: While reset is asserted and right after it, `pwm_o` and all three strobes are 0 and the counter is at 0.
- R2: With `cnt_en` high and prescale value N, the counter takes one step every N+1 clocks (N=0 means every clock). While `cnt_en` is low the counter and output hold and no strobe fires.
- R3: Mode code 00 (and the unused code 11) counts up 0,1,…,P and then returns to 0, so one cycle spans P+1 steps.
- R4: Mode code 01 counts down P,…,1,0 and then reloads P, so one cycle spans P+1 steps.
- R5: Mode code 10 counts 0 up to P and back down to 0, so one cycle spans 2·P steps.
- R6: A step that lands on the compare value fires the compare strobe. The up-compare action is applied if that step was upward, and the down-compare action if it was downward. In mode 00 every step, including the wrap to 0, counts as upward; in mode 01 every step counts as downward.
- R7: Action codes are 01 = drive low, 10 = drive high, and 00 or 11 = hold. An action takes effect in the same clock cycle in which the counter shows the new value and its strobe is high.
- R8: When several events land on one step, the non-hold actions are ranked period over compare over zero. Hence compare 0 with "high at zero, low at compare" keeps the output low.
- R9: Period and compare inputs take effect only at a cycle start: the step to 0 in modes 00 and 10, and the reload step in mode 01. A period change made mid-cycle leaves the current cycle's length unchanged.
- R10: While `out_en` is low, `pwm_o` is 0. The internal level keeps following events and reappears on the pin when `out_en` returns.
- R11: With period 0 in mode 00, the counter stays at 0, and the zero and period strobes both fire on every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counter and prescaler run enable |
| out_en | input | 1 | Pin drive enable |
| period_i | input | 16 | Requested period value |
| compare_i | input | 16 | Requested compare value |
| prescale_i | input | 12 | Clock divide value N (divide by N+1) |
| mode_i | input | 2 | Counting pattern: 00 up, 01 down, 10 up-down |
| act_zero_i | input | 2 | Reaction to arriving at zero |
| act_cmp_up_i | input | 2 | Reaction to an upward compare match |
| act_cmp_dn_i | input | 2 | Reaction to a downward compare match |
| act_period_i | input | 2 | Reaction to arriving at the period value |
| pwm_o | output | 1 | Gated PWM output |
| zero_stb_o | output | 1 | One-cycle strobe: counter arrived at zero |
| cmp_stb_o | output | 1 | One-cycle strobe: counter arrived at compare |
| period_stb_o | output | 1 | One-cycle strobe: counter arrived at period |

## Verification
The interesting collision is the zero arrival landing on the same step as a compare match (compare 0) or as a period arrival (period 0). In each case two actions compete for the output level. Directed cases force these coincidences: compare 0 and compare above the period give constant low and constant high outputs, and period 0 makes the zero and period strobes fire together. A bench reference model, run alongside with seeded random settings, checks the winning level on every cycle across all modes and action codes.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;

    typedef enum logic [1:0] {
        CM_UP   = 2'b00,
        CM_DOWN = 2'b01,
        CM_UPDN = 2'b10,
        CM_RSVD = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_KEEP  = 2'b00,
        ACT_LOW   = 2'b01,
        ACT_HIGH  = 2'b10,
        ACT_KEEP2 = 2'b11
    } act_e;

    typedef struct packed {
        logic zero;
        logic cmp_up;
        logic cmp_dn;
        logic prd;
    } evt_t;

endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
    parameter int PSC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] acc;
    } psc_st_t;

    psc_st_t st_d, st_q;
    logic    tick_c;

    always_comb begin
        st_d   = st_q;
        tick_c = run && (st_q.acc >= div);
        if (!run) begin
            st_d.acc = '0;
        end else if (tick_c) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = st_q.acc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = tick_c;

endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] compare_i,
    output evt_t             hit,
    output evt_t             stb,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] prd_sh_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
        logic [CNT_W-1:0] prd_sh;
        logic [CNT_W-1:0] cmp_sh;
        evt_t             stb;
    } ctr_st_t;

    ctr_st_t          st_d, st_q;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] eff_prd;
    logic [CNT_W-1:0] eff_cmp;
    logic             boundary;
    logic             step_up;
    logic             dir_n;
    evt_t             hit_c;

    // Next count, direction and cycle-start detection
    always_comb begin
        nxt      = st_q.cnt;
        boundary = 1'b0;
        step_up  = 1'b1;
        dir_n    = st_q.up;
        unique case (mode)
            CM_DOWN: begin
                step_up = 1'b0;
                dir_n   = 1'b0;
                if (st_q.cnt == '0) begin
                    nxt      = period_i;
                    boundary = 1'b1;
                end else begin
                    nxt = st_q.cnt - 1'b1;
                end
            end
            CM_UPDN: begin
                if (st_q.prd_sh == '0) begin
                    nxt      = '0;
                    boundary = 1'b1;
                    dir_n    = 1'b1;
                end else if (st_q.up) begin
                    if (st_q.cnt >= st_q.prd_sh) begin
                        nxt     = st_q.cnt - 1'b1;
                        dir_n   = 1'b0;
                        step_up = 1'b0;
                    end else begin
                        nxt = st_q.cnt + 1'b1;
                    end
                end else begin
                    if (st_q.cnt == '0) begin
                        nxt   = st_q.cnt + 1'b1;
                        dir_n = 1'b1;
                    end else begin
                        nxt      = st_q.cnt - 1'b1;
                        step_up  = 1'b0;
                        boundary = (st_q.cnt == {{(CNT_W-1){1'b0}}, 1'b1});
                    end
                end
            end
            default: begin
                dir_n = 1'b1;
                if (st_q.cnt >= st_q.prd_sh) begin
                    nxt      = '0;
                    boundary = 1'b1;
                end else begin
                    nxt = st_q.cnt + 1'b1;
                end
            end
        endcase
    end

    // Values in force for this step and event detection
    always_comb begin
        eff_prd       = boundary ? period_i  : st_q.prd_sh;
        eff_cmp       = boundary ? compare_i : st_q.cmp_sh;
        hit_c         = '0;
        if (tick) begin
            hit_c.zero   = (nxt == '0);
            hit_c.prd    = (nxt == eff_prd);
            hit_c.cmp_up = step_up  && (nxt == eff_cmp);
            hit_c.cmp_dn = !step_up && (nxt == eff_cmp);
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = hit_c;
        if (tick) begin
            st_d.cnt = nxt;
            st_d.up  = dir_n;
            if (boundary) begin
                st_d.prd_sh = period_i;
                st_d.cmp_sh = compare_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, up: 1'b1, prd_sh: '0, cmp_sh: '0, stb: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hit      = hit_c;
    assign stb      = st_q.stb;
    assign cnt_o    = st_q.cnt;
    assign prd_sh_o = st_q.prd_sh;

endmodule

// File: rtl/pwm_action.sv
`timescale 1ns/1ps
module pwm_action
    import pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  evt_t       hit,
    input  logic [1:0] act_zero,
    input  logic [1:0] act_cmp_up,
    input  logic [1:0] act_cmp_dn,
    input  logic [1:0] act_prd,
    output logic       level
);
    typedef struct packed {
        logic lvl;
    } act_st_t;

    act_st_t st_d, st_q;

    function automatic logic apply_act(input logic cur, input logic [1:0] code);
        logic res;
        unique case (act_e'(code))
            ACT_LOW:  res = 1'b0;
            ACT_HIGH: res = 1'b1;
            default:  res = cur;
        endcase
        return res;
    endfunction

    // Lowest rank applied first so higher ranks overwrite; hold leaves the value
    always_comb begin
        st_d = st_q;
        if (hit.zero)   st_d.lvl = apply_act(st_d.lvl, act_zero);
        if (hit.cmp_up) st_d.lvl = apply_act(st_d.lvl, act_cmp_up);
        if (hit.cmp_dn) st_d.lvl = apply_act(st_d.lvl, act_cmp_dn);
        if (hit.prd)    st_d.lvl = apply_act(st_d.lvl, act_prd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;

endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             out_en,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] compare_i,
    input  logic [PSC_W-1:0] prescale_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       act_zero_i,
    input  logic [1:0]       act_cmp_up_i,
    input  logic [1:0]       act_cmp_dn_i,
    input  logic [1:0]       act_period_i,
    output logic             pwm_o,
    output logic             zero_stb_o,
    output logic             cmp_stb_o,
    output logic             period_stb_o
);
    logic             tick;
    evt_t             hit_w;
    evt_t             stb_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] prd_sh_w;
    logic             level_w;

    pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cnt_en),
        .div   (prescale_i),
        .tick  (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (cnt_mode_e'(mode_i)),
        .period_i  (period_i),
        .compare_i (compare_i),
        .hit       (hit_w),
        .stb       (stb_w),
        .cnt_o     (cnt_w),
        .prd_sh_o  (prd_sh_w)
    );

    pwm_action u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit_w),
        .act_zero   (act_zero_i),
        .act_cmp_up (act_cmp_up_i),
        .act_cmp_dn (act_cmp_dn_i),
        .act_prd    (act_period_i),
        .level      (level_w)
    );

    assign pwm_o        = out_en & level_w;
    assign zero_stb_o   = stb_w.zero;
    assign cmp_stb_o    = stb_w.cmp_up | stb_w.cmp_dn;
    assign period_stb_o = stb_w.prd;

endmodule

// File: rtl/pwm_channel_chk.sv
`timescale 1ns/1ps
module pwm_channel_chk #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             out_en,
    input logic [PSC_W-1:0] prescale_i,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] prd_sh,
    input logic             pwm_o,
    input logic             zero_stb_o,
    input logic             cmp_stb_o,
    input logic             period_stb_o
);
    // R2: after a tick the divider restarts, so the next clock ticks only when dividing by one
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (tick == (cnt_en && prescale_i == '0)));

    // R2: a stopped counter produces no strobe on the following cycle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> !(zero_stb_o || cmp_stb_o || period_stb_o));

    // R3: the count never passes the period in force
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= prd_sh);

    // R7: the pin moves only on an event while the gate stays open
    a_r7_change_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && $past(out_en) && !zero_stb_o && !cmp_stb_o && !period_stb_o)
        |-> $stable(pwm_o));

    // R11: zero and period arrive together only with a zero period
    a_r11_zero_is_period: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_stb_o && period_stb_o) |-> (prd_sh == '0));

endmodule

bind pwm_channel pwm_channel_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_en       (cnt_en),
    .out_en       (out_en),
    .prescale_i   (prescale_i),
    .tick         (tick),
    .cnt          (cnt_w),
    .prd_sh       (prd_sh_w),
    .pwm_o        (pwm_o),
    .zero_stb_o   (zero_stb_o),
    .cmp_stb_o    (cmp_stb_o),
    .period_stb_o (period_stb_o)
);

// File: tb/tb_pwm_channel.sv
`timescale 1ns/1ps
module tb_pwm_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        out_en = 1'b0;
    logic [15:0] period_i = '0;
    logic [15:0] compare_i = '0;
    logic [11:0] prescale_i = '0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  act_zero_i = '0;
    logic [1:0]  act_cmp_up_i = '0;
    logic [1:0]  act_cmp_dn_i = '0;
    logic [1:0]  act_period_i = '0;
    logic        pwm_o, zero_stb_o, cmp_stb_o, period_stb_o;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R1";
    bit model_on = 1'b0;

    always #10 clk = ~clk;

    pwm_channel dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .out_en(out_en),
        .period_i(period_i), .compare_i(compare_i), .prescale_i(prescale_i),
        .mode_i(mode_i), .act_zero_i(act_zero_i), .act_cmp_up_i(act_cmp_up_i),
        .act_cmp_dn_i(act_cmp_dn_i), .act_period_i(act_period_i),
        .pwm_o(pwm_o), .zero_stb_o(zero_stb_o), .cmp_stb_o(cmp_stb_o),
        .period_stb_o(period_stb_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements
    int m_pc, m_cnt, m_psh, m_csh;
    bit m_up, m_lvl, m_z, m_c, m_p;

    function automatic bit act_apply(bit cur, logic [1:0] code);
        if (code == 2'b01) return 1'b0;
        if (code == 2'b10) return 1'b1;
        return cur;
    endfunction

    task automatic model_step();
        bit tk, bnd, su;
        int nx, ep, ec;
        tk   = cnt_en && (m_pc >= int'(prescale_i));
        m_pc = (!cnt_en || tk) ? 0 : m_pc + 1;
        m_z = 0; m_c = 0; m_p = 0;
        if (tk) begin
            bnd = 0; su = 1; nx = m_cnt;
            if (mode_i == 2'b01) begin
                su = 0; m_up = 0;
                if (m_cnt == 0) begin nx = int'(period_i); bnd = 1; end
                else nx = m_cnt - 1;
            end else if (mode_i == 2'b10) begin
                if (m_psh == 0) begin nx = 0; bnd = 1; m_up = 1; end
                else if (m_up) begin
                    if (m_cnt >= m_psh) begin nx = m_cnt - 1; m_up = 0; su = 0; end
                    else nx = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin nx = 1; m_up = 1; end
                    else begin nx = m_cnt - 1; su = 0; bnd = (nx == 0); end
                end
            end else begin
                m_up = 1;
                if (m_cnt >= m_psh) begin nx = 0; bnd = 1; end
                else nx = m_cnt + 1;
            end
            ep = bnd ? int'(period_i)  : m_psh;
            ec = bnd ? int'(compare_i) : m_csh;
            if (bnd) begin m_psh = int'(period_i); m_csh = int'(compare_i); end
            m_z = (nx == 0);
            m_p = (nx == ep);
            m_c = (nx == ec);
            if (m_z) m_lvl = act_apply(m_lvl, act_zero_i);
            if (m_c) m_lvl = act_apply(m_lvl, su ? act_cmp_up_i : act_cmp_dn_i);
            if (m_p) m_lvl = act_apply(m_lvl, act_period_i);
            m_cnt = nx;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc = 0; m_cnt = 0; m_psh = 0; m_csh = 0;
            m_up = 1; m_lvl = 0; m_z = 0; m_c = 0; m_p = 0;
        end else begin
            model_step();
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            check(cur_tag, {pwm_o, zero_stb_o, cmp_stb_o, period_stb_o},
                  {(out_en & m_lvl), m_z, m_c, m_p});
        end
    end

    task automatic setup(logic [1:0] md, int prd, int cmp, int psc,
                         logic [1:0] az, logic [1:0] acu, logic [1:0] acd, logic [1:0] ap);
        @(posedge clk); #2;
        mode_i = md; period_i = 16'(prd); compare_i = 16'(cmp); prescale_i = 12'(psc);
        act_zero_i = az; act_cmp_up_i = acu; act_cmp_dn_i = acd; act_period_i = ap;
        cnt_en = 1'b1; out_en = 1'b1;
    endtask

    task automatic wait_zero();
        do @(negedge clk); while (!zero_stb_o);
    endtask

    task automatic zero_gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!zero_stb_o);
    endtask

    task automatic count_high(int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin @(negedge clk); n += pwm_o; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R1: watchdog actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int g, h, p0, tr;
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {pwm_o, zero_stb_o, cmp_stb_o, period_stb_o}, 0);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        check("R1", {pwm_o, zero_stb_o, cmp_stb_o, period_stb_o}, 0);
        model_on = 1'b1;

        // R2: divide by three, period 3 -> 12 clocks per cycle
        cur_tag = "R2";
        setup(2'b00, 3, 1, 2, 2'b10, 2'b01, 2'b00, 2'b00);
        wait_zero(); wait_zero(); zero_gap(g);
        check("R2", g, 12);
        @(posedge clk); #2; cnt_en = 1'b0;
        count_high(1, p0);
        count_high(20, h);
        check("R2", h, 20 * p0);

        // R3: up mode period 4 -> 5 steps
        cur_tag = "R3";
        setup(2'b00, 4, 2, 0, 2'b10, 2'b01, 2'b00, 2'b00);
        wait_zero(); wait_zero(); zero_gap(g);
        check("R3", g, 5);

        // R4: down mode period 3 -> 4 steps
        cur_tag = "R4";
        setup(2'b01, 3, 1, 0, 2'b10, 2'b00, 2'b01, 2'b00);
        wait_zero(); wait_zero(); zero_gap(g);
        check("R4", g, 4);

        // R5: up-down period 3 -> 6 steps
        cur_tag = "R5";
        setup(2'b10, 3, 1, 0, 2'b00, 2'b10, 2'b01, 2'b00);
        wait_zero(); wait_zero(); zero_gap(g);
        check("R5", g, 6);

        // R6: up-down period 6, high on upward match at 2, low on downward match
        cur_tag = "R6";
        setup(2'b10, 6, 2, 0, 2'b00, 2'b10, 2'b01, 2'b00);
        wait_zero(); wait_zero(); count_high(24, h);
        check("R6", h, 16);

        // R8: compare 0 collides with zero, compare wins -> always low
        cur_tag = "R8";
        setup(2'b00, 7, 0, 0, 2'b10, 2'b01, 2'b00, 2'b00);
        wait_zero(); wait_zero(); count_high(32, h);
        check("R8", h, 0);
        // compare above period never matches -> always high
        setup(2'b00, 7, 9, 0, 2'b10, 2'b01, 2'b00, 2'b00);
        wait_zero(); wait_zero(); count_high(32, h);
        check("R8", h, 32);
        // period action outranks compare when both land on P
        setup(2'b00, 5, 5, 0, 2'b00, 2'b10, 2'b00, 2'b01);
        wait_zero(); wait_zero(); count_high(24, h);
        check("R8", h, 0);

        // R9: period change mid-cycle applies one cycle later
        cur_tag = "R9";
        setup(2'b00, 9, 3, 0, 2'b10, 2'b01, 2'b00, 2'b00);
        wait_zero(); wait_zero();
        period_i = 16'd3;
        zero_gap(g); check("R9", g, 10);
        zero_gap(g); check("R9", g, 4);

        // R10: gate closed -> pin low; reopened -> 4 of 8 high
        cur_tag = "R10";
        setup(2'b00, 7, 4, 0, 2'b10, 2'b01, 2'b00, 2'b00);
        @(posedge clk); #2; out_en = 1'b0;
        count_high(40, h); check("R10", h, 0);
        @(posedge clk); #2; out_en = 1'b1;
        wait_zero(); count_high(16, h); check("R10", h, 8);

        // R7: hold codes leave the pin unchanged
        cur_tag = "R7";
        setup(2'b00, 5, 2, 0, 2'b11, 2'b00, 2'b11, 2'b00);
        @(negedge clk); p0 = pwm_o; tr = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_o != p0[0]) tr++;
        end
        check("R7", tr, 0);

        // R11: period 0 -> zero and period strobes on every step
        cur_tag = "R11";
        setup(2'b00, 0, 3, 0, 2'b10, 2'b01, 2'b00, 2'b00);
        wait_zero(); wait_zero();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R11", {zero_stb_o, period_stb_o}, 3);
        end

        // Random settings judged every cycle against the model (R7 actions, all modes)
        cur_tag = "R7";
        for (int s = 0; s < 300; s++) begin
            @(posedge clk); #2;
            mode_i       = 2'($urandom % 4);
            if (($urandom % 3) != 0) period_i  = 16'($urandom % 13);
            compare_i    = 16'($urandom % 15);
            prescale_i   = 12'($urandom % 4);
            act_zero_i   = 2'($urandom % 4);
            act_cmp_up_i = 2'($urandom % 4);
            act_cmp_dn_i = 2'($urandom % 4);
            act_period_i = 2'($urandom % 4);
            cnt_en       = ($urandom % 8) != 0;
            out_en       = ($urandom % 8) != 0;
            repeat (40) @(negedge clk);
        end

        model_on = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule